// File: doc/BRIEF.md
# DRAM Bank Command State Machine

This block is the per-bank decision engine of a DRAM controller. It remembers whether its bank has a row open, and which row that is. It also tracks whether the bank is asleep (powered down or in self-refresh) or blocked from new work because a refresh is pending. Each cycle it looks at the request a scheduler offers for this bank and at two lookahead hints. From these it proposes the next DRAM command: activate, read, write, read or write with auto-precharge, or precharge. Timing-constraint checking, queueing and refresh planning sit outside. The controller reports back, on a separate strobe, the command it actually issued, and only that strobe moves the bank state.

The page policy is fixed by a parameter. Open keeps rows open. Closed always auto-precharges. Open-adaptive auto-precharges when the queue shows work of the same type for other rows only. Closed-adaptive keeps the row open only while more hits of the same type are queued. Once an activate has been issued, the block holds on to the request that caused it, so that the activation is always followed by a column access to that row. A different request can take the held one's place only if it targets the same open row.

Top module: `bank_cmd_ctrl`

## Requirements
- R1: An issued ACT (issue code 1) marks the bank activated and records the row of the current request as the open row. An issued per-bank precharge (6) or all-bank precharge (7) marks it precharged.
- R2: An issued ACT sets an internal hold flag. An issued RD (2), WR (3), RDA (4), WRA (5), or a precharge (6 or 7) clears it.
- R3: RD and WR leave the bank activated with the same open row. RDA and WRA return it to precharged.
- R4: While the hold flag is set, an offered request becomes current only if its row equals the open row; otherwise the held request stays current. While it is clear, the offered request always becomes current. In a cycle where ACT is issued, the current request does not change.
- R5: The proposal is registered and appears one cycle after its inputs. With no request offered, bank asleep, bank blocked, or timing_ok low, the next cycle shows prop_valid=0 and prop_cmd=0 (NOP). After reset, all outputs are 0.
- R6: In every policy, a precharged bank with a valid request proposes ACT (code 1).
- R7: Open policy (POLICY=0), activated bank: a row hit proposes RD (2) for a read (req_kind=01) or WR (3) for a write (req_kind=10). A row miss proposes per-bank precharge (6).
- R8: Closed policy (POLICY=1), activated bank: always proposes RDA (4) for a read or WRA (5) for a write.
- R9: Open-adaptive policy (POLICY=2), activated bank: a hit proposes RDA/WRA when more_same_kind=1 and more_row_hit=0, and RD/WR otherwise. A miss proposes 6.
- R10: Closed-adaptive policy (POLICY=3), activated bank: a hit proposes RD/WR when more_row_hit=1, and RDA/WRA otherwise. A miss proposes 6.
- R11: Issuing sleep entry (8) sets asleep. Sleep exit (9), refresh (10) and refresh-management (11) clear asleep. Refresh and refresh-management also clear blocked. A blk_set pulse sets blocked, and it wins over a clear issued in the same cycle.
- R12: seq_viol is high in any cycle where code 8, 9, 10 or 11 is issued while the hold flag is set.
- R13: A current request whose kind is neither 01 nor 10, evaluated while the bank is awake and a request is offered, proposes nothing and sets kind_err. kind_err then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Scheduler offers a request for this bank |
| req_row | input | ROW_W | Row of the offered request |
| req_kind | input | 2 | 01 read, 10 write, other values illegal |
| more_same_kind | input | 1 | Another request of the same type is queued for this bank |
| more_row_hit | input | 1 | A queued request of the same type hits the open row |
| timing_ok | input | 1 | Timing constraints allow a proposal this cycle |
| blk_set | input | 1 | Mark the bank blocked |
| iss_valid | input | 1 | A command was issued to this bank |
| iss_cmd | input | 4 | Code of the issued command |
| prop_cmd | output | 4 | Proposed command code, registered |
| prop_valid | output | 1 | Proposal is valid |
| kind_err | output | 1 | Sticky illegal-request-type flag |
| seq_viol | output | 1 | Power or refresh command issued while holding a request |

## Verification
The hardest situation to reach is a request held after an activate while the scheduler has already moved on. Here the offered request targets another row, yet the proposal must still be a column access for the held one. The directed sequence issues ACT, then offers a different row, and then a same-row request of the other type, with the lookahead flags stepped through all four combinations. A long random phase follows, with issues arriving in arbitrary order. It reaches sleep, refresh and block interleavings with the hold flag set, and a behavioural model of all four policies is compared every cycle.

// File: rtl/bank_cmd_pkg.sv
// Shared encodings for the bank command state machine.
package bank_cmd_pkg;

    // Command codes, used both for proposals and for the issued-command strobe.
    typedef enum logic [3:0] {
        C_NOP    = 4'd0,
        C_ACT    = 4'd1,
        C_RD     = 4'd2,
        C_WR     = 4'd3,
        C_RDA    = 4'd4,
        C_WRA    = 4'd5,
        C_PRE    = 4'd6,
        C_PREALL = 4'd7,
        C_SLEEP  = 4'd8,
        C_WAKE   = 4'd9,
        C_REF    = 4'd10,
        C_RFM    = 4'd11
    } bank_cmd_e;

    // Page policy selection.
    typedef enum logic [1:0] {
        POL_OPEN        = 2'd0,
        POL_CLOSED      = 2'd1,
        POL_OPEN_ADPT   = 2'd2,
        POL_CLOSED_ADPT = 2'd3
    } page_pol_e;

    localparam logic [1:0] KIND_RD = 2'b01;
    localparam logic [1:0] KIND_WR = 2'b10;

endpackage

// File: rtl/bank_row_tracker.sv
// Bank state tracker: row state, open row, hold flag, asleep and blocked.
// Assumes iss_cmd is only meaningful when iss_valid is high, and that
// cur_row carries the current request at the time an ACT is issued.
module bank_row_tracker
    import bank_cmd_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [3:0]       iss_cmd,
    input  logic             blk_set,
    input  logic [ROW_W-1:0] cur_row,
    output logic             act_q,
    output logic [ROW_W-1:0] open_row_q,
    output logic             keep_q,
    output logic             sleep_q,
    output logic             blk_q,
    output logic             seq_viol
);

    logic is_pwr;

    // Row state, open row and hold flag follow issued ACT/column/precharge commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q      <= 1'b0;
            open_row_q <= '0;
            keep_q     <= 1'b0;
        end else if (iss_valid) begin
            case (iss_cmd)
                C_ACT: begin
                    act_q      <= 1'b1;
                    open_row_q <= cur_row;
                    keep_q     <= 1'b1;
                end
                C_RD, C_WR: keep_q <= 1'b0;
                C_RDA, C_WRA, C_PRE, C_PREALL: begin
                    act_q  <= 1'b0;
                    keep_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Asleep flag: set by sleep entry, cleared by exit or any refresh flavour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q <= 1'b0;
        end else if (iss_valid) begin
            if (iss_cmd == C_SLEEP)
                sleep_q <= 1'b1;
            else if (iss_cmd == C_WAKE || iss_cmd == C_REF || iss_cmd == C_RFM)
                sleep_q <= 1'b0;
        end
    end

    // Blocked flag: set by the refresh planner, cleared by a refresh; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_q <= 1'b0;
        else if (blk_set)
            blk_q <= 1'b1;
        else if (iss_valid && (iss_cmd == C_REF || iss_cmd == C_RFM))
            blk_q <= 1'b0;
    end

    // Flag a power or refresh command arriving while a request is held.
    always_comb begin
        is_pwr   = (iss_cmd == C_SLEEP) || (iss_cmd == C_WAKE) ||
                   (iss_cmd == C_REF)   || (iss_cmd == C_RFM);
        seq_viol = iss_valid && keep_q && is_pwr;
    end

    assert_act_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_cmd == C_ACT) |=> (act_q && open_row_q == $past(cur_row)));

    assert_act_sets_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_cmd == C_ACT) |=> keep_q);

    assert_col_clears_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_cmd == C_RD || iss_cmd == C_WR || iss_cmd == C_PRE)) |=> !keep_q);

    assert_plain_keeps_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_cmd == C_RD || iss_cmd == C_WR))
        |=> ($stable(open_row_q) && act_q == $past(act_q)));

    assert_auto_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_cmd == C_RDA || iss_cmd == C_WRA)) |=> !act_q);

    assert_ref_unblocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_cmd == C_REF && !blk_set) |=> (!blk_q && !sleep_q));

endmodule

// File: rtl/bank_req_pick.sv
// Current-request selection. While the hold flag is set, only a request for the
// open row may displace the held one. The current request register is
// frozen in the cycle an ACT is issued, so the open row matches the ACT's request.
module bank_req_pick #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_row,
    input  logic [1:0]       req_kind,
    input  logic             awake,
    input  logic             keep_q,
    input  logic [ROW_W-1:0] open_row_q,
    input  logic             act_issue,
    output logic [ROW_W-1:0] sel_row,
    output logic [1:0]       sel_kind,
    output logic [ROW_W-1:0] cur_row_q
);

    logic [1:0] cur_kind_q;
    logic       take_new;

    // Choose between the offered request and the held one.
    always_comb begin
        take_new = !keep_q || (req_row == open_row_q);
        sel_row  = take_new ? req_row  : cur_row_q;
        sel_kind = take_new ? req_kind : cur_kind_q;
    end

    // Remember the chosen request as the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row_q  <= '0;
            cur_kind_q <= '0;
        end else if (req_valid && awake && !act_issue) begin
            cur_row_q  <= sel_row;
            cur_kind_q <= sel_kind;
        end
    end

    assert_held_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_q && req_valid && awake && !act_issue && req_row != open_row_q)
        |=> $stable(cur_row_q));

    assert_act_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_issue |=> $stable(cur_row_q));

endmodule

// File: rtl/bank_policy_decode.sv
// Next-command decode for one page policy, picked at elaboration time.
// Assumes sel_kind is a legal read or write code; the top suppresses the
// proposal otherwise.
module bank_policy_decode
    import bank_cmd_pkg::*;
#(
    parameter int        ROW_W  = 8,
    parameter page_pol_e POLICY = POL_OPEN
) (
    input  logic             act_q,
    input  logic [ROW_W-1:0] open_row_q,
    input  logic [ROW_W-1:0] sel_row,
    input  logic [1:0]       sel_kind,
    input  logic             more_same_kind,
    input  logic             more_row_hit,
    output logic [3:0]       next_cmd
);

    logic       hit;
    logic [3:0] plain_cmd;
    logic [3:0] auto_cmd;
    logic [3:0] act_cmd;

    // Common terms: row hit and the plain/auto column command for this request.
    always_comb begin
        hit       = (sel_row == open_row_q);
        plain_cmd = (sel_kind == KIND_RD) ? C_RD  : C_WR;
        auto_cmd  = (sel_kind == KIND_RD) ? C_RDA : C_WRA;
    end

    generate
        if (POLICY == POL_OPEN) begin : g_open
            // Open: column access on hit, close the row on miss.
            always_comb act_cmd = hit ? plain_cmd : C_PRE;
        end else if (POLICY == POL_CLOSED) begin : g_closed
            // Closed: every column access auto-precharges.
            always_comb act_cmd = auto_cmd;
        end else if (POLICY == POL_OPEN_ADPT) begin : g_open_adpt
            // Open-adaptive: auto-precharge if queued work only targets other rows.
            always_comb begin
                if (!hit)
                    act_cmd = C_PRE;
                else if (more_same_kind && !more_row_hit)
                    act_cmd = auto_cmd;
                else
                    act_cmd = plain_cmd;
            end
        end else begin : g_closed_adpt
            // Closed-adaptive: stay open only while more hits are queued.
            always_comb begin
                if (!hit)
                    act_cmd = C_PRE;
                else if (more_row_hit)
                    act_cmd = plain_cmd;
                else
                    act_cmd = auto_cmd;
            end
        end
    endgenerate

    // A precharged bank always wants an activate first.
    always_comb next_cmd = act_q ? act_cmd : C_ACT;

endmodule

// File: rtl/bank_cmd_ctrl.sv
// Per-bank command state machine. Proposes the next DRAM command for one bank
// from the scheduler's offered request, registered one cycle later. Bank state
// moves only on the issued-command strobe. Assumes the scheduler's lookahead
// hints refer to the request offered in the same cycle.
module bank_cmd_ctrl
    import bank_cmd_pkg::*;
#(
    parameter int        ROW_W  = 8,
    parameter page_pol_e POLICY = POL_OPEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_row,
    input  logic [1:0]       req_kind,
    input  logic             more_same_kind,
    input  logic             more_row_hit,
    input  logic             timing_ok,
    input  logic             blk_set,
    input  logic             iss_valid,
    input  logic [3:0]       iss_cmd,
    output logic [3:0]       prop_cmd,
    output logic             prop_valid,
    output logic             kind_err,
    output logic             seq_viol
);

    logic             act_q, keep_q, sleep_q, blk_q, awake, act_issue;
    logic             consider, kind_ok;
    logic [ROW_W-1:0] open_row_q, cur_row_q, sel_row;
    logic [1:0]       sel_kind;
    logic [3:0]       next_cmd;

    // Gating terms shared by selection and proposal.
    always_comb begin
        awake     = !sleep_q && !blk_q;
        act_issue = iss_valid && (iss_cmd == C_ACT);
        consider  = req_valid && awake;
        kind_ok   = (sel_kind == KIND_RD) || (sel_kind == KIND_WR);
    end

    bank_row_tracker #(.ROW_W(ROW_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (iss_valid),
        .iss_cmd    (iss_cmd),
        .blk_set    (blk_set),
        .cur_row    (cur_row_q),
        .act_q      (act_q),
        .open_row_q (open_row_q),
        .keep_q     (keep_q),
        .sleep_q    (sleep_q),
        .blk_q      (blk_q),
        .seq_viol   (seq_viol)
    );

    bank_req_pick #(.ROW_W(ROW_W)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_row    (req_row),
        .req_kind   (req_kind),
        .awake      (awake),
        .keep_q     (keep_q),
        .open_row_q (open_row_q),
        .act_issue  (act_issue),
        .sel_row    (sel_row),
        .sel_kind   (sel_kind),
        .cur_row_q  (cur_row_q)
    );

    bank_policy_decode #(.ROW_W(ROW_W), .POLICY(POLICY)) u_dec (
        .act_q          (act_q),
        .open_row_q     (open_row_q),
        .sel_row        (sel_row),
        .sel_kind       (sel_kind),
        .more_same_kind (more_same_kind),
        .more_row_hit   (more_row_hit),
        .next_cmd       (next_cmd)
    );

    // Register the proposal; nothing when idle, gated, or the request is illegal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prop_valid <= 1'b0;
            prop_cmd   <= C_NOP;
        end else if (consider && kind_ok && timing_ok) begin
            prop_valid <= 1'b1;
            prop_cmd   <= next_cmd;
        end else begin
            prop_valid <= 1'b0;
            prop_cmd   <= C_NOP;
        end
    end

    // Sticky flag for a request type that is neither read nor write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kind_err <= 1'b0;
        else if (consider && !kind_ok)
            kind_err <= 1'b1;
    end

    assert_idle_no_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || sleep_q || blk_q || !timing_ok) |=> (!prop_valid && prop_cmd == C_NOP));

    assert_precharged_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (consider && timing_ok && !act_q) |=> (!prop_valid || prop_cmd == C_ACT));

    assert_valid_not_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prop_valid |-> (prop_cmd != C_NOP));

    assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        kind_err |=> kind_err);

    assert_err_no_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (consider && !kind_ok) |=> !prop_valid);

endmodule

// File: tb/bank_cmd_ctrl_tb.sv
// Bench: four instances, one per page policy, driven with the same stimulus
// and compared every cycle against a behavioural model.
module bank_cmd_ctrl_tb;
    import bank_cmd_pkg::*;

    localparam int RW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          b_rv = 0, b_mk = 0, b_mh = 0, b_tok = 0, b_iv = 0, b_blk = 0;
    logic [RW-1:0] b_row = '0;
    logic [1:0]    b_kind = '0;
    logic [3:0]    b_ic = '0;

    logic [3:0] d_cmd  [4];
    logic       d_val  [4];
    logic       d_err  [4];
    logic       d_viol [4];

    for (genvar p = 0; p < 4; p++) begin : g_pol
        bank_cmd_ctrl #(.ROW_W(RW), .POLICY(page_pol_e'(p))) u_dut (
            .clk(clk), .rst_n(rst_n), .req_valid(b_rv), .req_row(b_row),
            .req_kind(b_kind), .more_same_kind(b_mk), .more_row_hit(b_mh),
            .timing_ok(b_tok), .blk_set(b_blk), .iss_valid(b_iv), .iss_cmd(b_ic),
            .prop_cmd(d_cmd[p]), .prop_valid(d_val[p]), .kind_err(d_err[p]),
            .seq_viol(d_viol[p]));
    end

    // Model state per policy.
    int    m_act[4], m_open[4], m_keep[4], m_sleep[4], m_blk[4];
    int    m_cur_row[4], m_cur_kind[4], m_cmd[4], m_val[4], m_err[4];
    string m_tag[4];
    int    n_cmp = 0, n_bad = 0;
    string s_tag = "R5";

    function automatic int pick(int p, int act, bit hit, bit rd, bit mk, bit mh);
        int plain, auto_c;
        plain  = rd ? 2 : 3;
        auto_c = rd ? 4 : 5;
        if (act == 0) return 1;
        if (p == 0) return hit ? plain : 6;
        if (p == 1) return auto_c;
        if (!hit) return 6;
        if (p == 2) return (mk && !mh) ? auto_c : plain;
        return mh ? plain : auto_c;
    endfunction

    task automatic m_step(int p);
        int ch_row, ch_kind;
        bit aw;
        aw = (m_sleep[p] == 0) && (m_blk[p] == 0);
        if (m_keep[p] != 0 && int'(b_row) != m_open[p]) begin
            ch_row = m_cur_row[p]; ch_kind = m_cur_kind[p];
        end else begin
            ch_row = int'(b_row); ch_kind = int'(b_kind);
        end
        m_val[p] = 0; m_cmd[p] = 0; m_tag[p] = "R5";
        if (b_rv && aw) begin
            if (ch_kind != 1 && ch_kind != 2) begin
                m_err[p] = 1; m_tag[p] = "R13";
            end else if (b_tok) begin
                m_val[p] = 1;
                m_cmd[p] = pick(p, m_act[p], ch_row == m_open[p], ch_kind == 1, b_mk, b_mh);
                if (m_act[p] == 0) m_tag[p] = "R6";
                else m_tag[p] = (p == 0) ? "R7" : (p == 1) ? "R8" : (p == 2) ? "R9" : "R10";
            end
        end
        if (b_iv) begin
            case (int'(b_ic))
                1: begin m_act[p] = 1; m_open[p] = m_cur_row[p]; m_keep[p] = 1; end
                2, 3: m_keep[p] = 0;
                4, 5, 6, 7: begin m_act[p] = 0; m_keep[p] = 0; end
                8: m_sleep[p] = 1;
                9: m_sleep[p] = 0;
                10, 11: begin m_sleep[p] = 0; if (!b_blk) m_blk[p] = 0; end
                default: ;
            endcase
        end
        if (b_blk) m_blk[p] = 1;
        if (b_rv && aw && !(b_iv && b_ic == 4'd1)) begin
            m_cur_row[p] = ch_row; m_cur_kind[p] = ch_kind;
        end
    endtask

    // Reference model advances on each rising edge.
    always @(posedge clk) begin
        for (int p = 0; p < 4; p++) begin
            if (!rst_n) begin
                m_act[p] = 0; m_open[p] = 0; m_keep[p] = 0; m_sleep[p] = 0; m_blk[p] = 0;
                m_cur_row[p] = 0; m_cur_kind[p] = 0; m_cmd[p] = 0; m_val[p] = 0;
                m_err[p] = 0; m_tag[p] = "R5";
            end else begin
                m_step(p);
            end
        end
    end

    task automatic chk(string rq, int p, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s (scenario %s) policy=%0d actual=%0d expected=%0d", rq, s_tag, p, got, exp);
        end
    endtask

    task automatic compare();
        int ev;
        for (int p = 0; p < 4; p++) begin
            chk(m_tag[p], p, int'(d_cmd[p]), m_cmd[p]);
            chk(m_tag[p], p, int'(d_val[p]), m_val[p]);
            chk("R13", p, int'(d_err[p]), m_err[p]);
            ev = (b_iv && m_keep[p] != 0 && b_ic >= 4'd8 && b_ic <= 4'd11) ? 1 : 0;
            chk("R12", p, int'(d_viol[p]), ev);
        end
    endtask

    task automatic cyc(bit rv, int row, int kind, bit mk, bit mh, bit tok, bit iv, int ic, bit blk);
        b_rv = rv; b_row = RW'(row); b_kind = 2'(kind); b_mk = mk; b_mh = mh;
        b_tok = tok; b_iv = iv; b_ic = 4'(ic); b_blk = blk;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R5: reset state
        s_tag = "R5";
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
        // R6: precharged bank proposes ACT
        s_tag = "R6";  cyc(1, 5, 1, 0, 0, 1, 0, 0, 0);
        // R1: issue ACT for row 5
        s_tag = "R1";  cyc(1, 5, 1, 0, 0, 1, 1, 1, 0);
        // R7 R8 R9 R10: hit decisions over all hint combinations, read then write
        s_tag = "R9";
        for (int k = 1; k <= 2; k++)
            for (int f = 0; f < 4; f++) cyc(1, 5, k, f[0], f[1], 1, 0, 0, 0);
        // R4: held request survives a foreign row, then same-row request replaces it
        s_tag = "R4";  cyc(1, 9, 1, 1, 0, 1, 0, 0, 0);
        cyc(1, 9, 2, 0, 1, 1, 0, 0, 0);
        cyc(1, 5, 2, 0, 0, 1, 0, 0, 0);
        // R2 R3: issue RD releases the hold, next foreign row is a miss
        s_tag = "R2";  cyc(1, 5, 1, 0, 0, 1, 1, 2, 0);
        s_tag = "R3";  cyc(1, 9, 1, 0, 0, 1, 0, 0, 0);
        // R1: precharge then ACT again
        s_tag = "R1";  cyc(1, 9, 1, 0, 0, 1, 1, 6, 0);
        cyc(1, 9, 2, 0, 0, 1, 1, 1, 0);
        s_tag = "R3";  cyc(1, 9, 2, 0, 0, 1, 1, 5, 0);
        cyc(1, 9, 2, 0, 0, 1, 0, 0, 0);
        // R11: sleep, wake, block, refresh-management
        s_tag = "R11"; cyc(1, 3, 1, 0, 0, 1, 1, 8, 0);
        cyc(1, 3, 1, 0, 0, 1, 0, 0, 0);
        cyc(1, 3, 1, 0, 0, 1, 1, 9, 0);
        cyc(1, 3, 1, 0, 0, 1, 0, 0, 1);
        cyc(1, 3, 1, 0, 0, 1, 0, 0, 0);
        cyc(1, 3, 1, 0, 0, 1, 1, 11, 0);
        cyc(1, 3, 1, 0, 0, 1, 0, 0, 0);
        // R12: refresh issued while holding
        s_tag = "R12"; cyc(1, 3, 1, 0, 0, 1, 1, 1, 0);
        cyc(1, 3, 1, 0, 0, 1, 1, 10, 0);
        cyc(1, 3, 1, 0, 0, 1, 1, 2, 0);
        // R5: timing not ready, no request
        s_tag = "R5";  cyc(1, 3, 1, 0, 0, 0, 0, 0, 0);
        cyc(0, 3, 1, 0, 0, 1, 0, 0, 0);
        // R13: illegal kind with hold clear
        s_tag = "R13"; cyc(1, 4, 0, 0, 0, 1, 0, 0, 0);
        cyc(1, 4, 1, 0, 0, 1, 0, 0, 0);
        // Mixed random phase
        s_tag = "RND";
        for (int i = 0; i < 2000; i++) begin
            int kr;
            kr = ($urandom % 50 == 0) ? 3 : 1 + ($urandom % 2);
            cyc(($urandom % 4) != 0, $urandom % 4, kr, $urandom % 2, $urandom % 2,
                ($urandom % 5) != 0, ($urandom % 5) < 2, $urandom % 12, ($urandom % 20) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule